// File: doc/BRIEF.md
# Synchronous-to-Start-Stop Receive Restorer

This block sits on the receive side of a line adapter that carries start-stop characters over a synchronous channel. Each pulse of a receive bit strobe samples one bit of the incoming stream. The block locates character boundaries from the start bit and collects the payload for the selected character length. It then re-emits every character as an asynchronous element sequence timed by a 16x timing tick. A mark is 1; a space, start bit or break is 0.

The upstream sender may have dropped a stop bit to make up for a slightly faster local clock. When that happens, the stop position carries a space, which is the start bit of the next character. The block restores the missing stop on its output. To absorb the extra element, it shortens stop elements while another character is waiting. A long run of space is forwarded as a break. Two selects connect the input straight to the output: bypass, and a higher-speed mode in which the character buffer is taken out of the path.

Top module: `rx_stop_restore`

## Requirements
- R1: After reset, and whenever no character is in progress, async_out is 1 (mark).
- R2: A character starts when a 0 is sampled on a rx_bit_stb pulse while no character is in progress. The payload bits that follow are re-emitted in arrival order after a 0 start element and before a 1 stop element. Start and payload elements each last 16 tick16 pulses.
- R3: The total character length, counting start, payload and stop, is 8 + len_sel: 00 gives 8, 01 gives 9, 10 gives 10 and 11 gives 11. The payload therefore has 6 + len_sel bits.
- R4: If a 0 is sampled at the stop position of a character that is not all space, the character is still emitted with a 1 stop element, and that 0 is taken as the start bit of the next character.
- R5: A stop element lasts 16 ticks when no other character is waiting. If another character is waiting, it lasts 14 ticks with ext_range = 0 and 12 ticks with ext_range = 1, and the next start element follows at once.
- R6: If the start position, all payload positions and the stop position are sampled as 0, this is a break. async_out stays 0 beyond the character until a 1 is sampled on the input. A 16-tick mark stop element then follows.
- R7: While bypass is 1, async_out equals line_in in the same cycle, and the converter stays idle, so it emits nothing for the stimulus it saw in that time.
- R8: While hs_direct is 1, async_out equals line_in in the same cycle, and the character buffer is held empty.
- R9: Traffic at the nominal rate in the extended range, with at most one dropped stop bit in every four characters, is delivered completely and in order, without loss in the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit_stb | input | 1 | One-cycle strobe: sample line_in as the next received bit |
| line_in | input | 1 | Synchronous receive data, 1 = mark |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| len_sel | input | 2 | Character length select (8 + len_sel bits) |
| ext_range | input | 1 | 1 = extended signalling range (deeper stop shortening) |
| bypass | input | 1 | 1 = input wired straight to output |
| hs_direct | input | 1 | 1 = higher-speed mode, buffer removed, input drives output |
| async_out | output | 1 | Restored start-stop output, 1 = mark |

## Verification
The bench builds the block with its default parameters: 16 ticks per element, shortening by 2 and 4 ticks, and a four-entry buffer. It delivers one tick every second clock and one bit strobe every 32 clocks, so input and output run at exactly the same nominal rate. With these values, the start-to-start distance after a dropped stop bit is an exact cycle count in both ranges (252 and 248 clocks for 8-bit characters). A stream with one dropped stop in every four characters keeps a small backlog that the four entries must hold. A break held for twelve extra bit times reaches the hold state of the output, which proves that the space is stretched and not just emitted for one character.

// File: rtl/rx_stop_restore.sv
module rx_stop_restore #(
  parameter int OVS         = 16,
  parameter int SHORT_BASIC = 2,
  parameter int SHORT_EXT   = 4,
  parameter int DEPTH       = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit_stb,
  input  logic       line_in,
  input  logic       tick16,
  input  logic [1:0] len_sel,
  input  logic       ext_range,
  input  logic       bypass,
  input  logic       hs_direct,
  output logic       async_out
);
  localparam int PMAX = 9;
  localparam int CW   = $clog2(OVS);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [1:0] {F_HUNT = 2'd0, F_DATA = 2'd1, F_BRK = 2'd2} fst_t;
  typedef enum logic [2:0] {E_IDLE = 3'd0, E_START = 3'd1, E_DATA = 3'd2,
                            E_HOLD = 3'd3, E_STOP = 3'd4} est_t;

  logic            direct;
  logic [3:0]      plen;
  assign direct = bypass | hs_direct;
  assign plen   = 4'd6 + {2'b00, len_sel};

  // framer
  fst_t            fst;
  logic [3:0]      fidx;
  logic [PMAX-1:0] fpay;
  logic            brk_hold;
  logic            at_stop, push;
  logic [PMAX:0]   push_data;

  assign at_stop   = rx_bit_stb && (fst == F_DATA) && (fidx == plen);
  assign push      = at_stop && !direct;
  assign push_data = {(!line_in && fpay == '0), fpay};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst <= F_HUNT; fidx <= '0; fpay <= '0; brk_hold <= 1'b0;
    end else if (direct) begin
      fst <= F_HUNT; fidx <= '0; fpay <= '0; brk_hold <= 1'b0;
    end else if (rx_bit_stb) begin
      case (fst)
        F_HUNT: if (!line_in) begin
          fst <= F_DATA; fidx <= '0; fpay <= '0;
        end
        F_DATA: if (fidx == plen) begin
          if (line_in) fst <= F_HUNT;
          else if (fpay == '0) begin
            fst <= F_BRK; brk_hold <= 1'b1;
          end else begin
            fidx <= '0; fpay <= '0;
          end
        end else begin
          fpay[fidx] <= line_in;
          fidx       <= fidx + 4'd1;
        end
        F_BRK: if (line_in) begin
          fst <= F_HUNT; brk_hold <= 1'b0;
        end
        default: fst <= F_HUNT;
      endcase
    end
  end

  // character buffer
  logic [PMAX:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   fcnt;
  logic          empty, pop;
  assign empty = (fcnt == '0);

  always_ff @(posedge clk) if (push) mem[wp] <= push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fcnt <= '0;
    end else if (direct) begin
      wp <= '0; rp <= '0; fcnt <= '0;
    end else begin
      if (push) wp <= (int'(wp) == DEPTH-1) ? '0 : wp + 1'b1;
      if (pop)  rp <= (int'(rp) == DEPTH-1) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   fcnt <= fcnt + 1'b1;
        2'b01:   fcnt <= fcnt - 1'b1;
        default: fcnt <= fcnt;
      endcase
    end
  end

  // element emitter
  est_t            est;
  logic [CW-1:0]   ecnt;
  logic [3:0]      ebi;
  logic [PMAX-1:0] esh;
  logic            ebrk;
  logic            bit_end, stop_done, line_q;
  int              lim;

  always_comb begin
    lim = OVS;
    if (!empty) lim = OVS - (ext_range ? SHORT_EXT : SHORT_BASIC);
  end

  assign bit_end   = (ecnt == CW'(OVS-1));
  assign stop_done = (int'(ecnt) >= lim - 1);
  assign pop = tick16 && !direct && !empty &&
               ((est == E_IDLE) || (est == E_STOP && stop_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est <= E_IDLE; ecnt <= '0; ebi <= '0; esh <= '0; ebrk <= 1'b0;
    end else if (direct) begin
      est <= E_IDLE; ecnt <= '0; ebi <= '0; esh <= '0; ebrk <= 1'b0;
    end else if (tick16) begin
      if (pop) begin
        est  <= E_START; ecnt <= '0;
        esh  <= mem[rp][PMAX-1:0];
        ebrk <= mem[rp][PMAX];
      end else begin
        case (est)
          E_IDLE: ecnt <= '0;
          E_START: if (bit_end) begin
            est <= E_DATA; ecnt <= '0; ebi <= '0;
          end else ecnt <= ecnt + 1'b1;
          E_DATA: if (bit_end) begin
            ecnt <= '0;
            esh  <= esh >> 1;
            if (ebi == plen - 4'd1) est <= ebrk ? E_HOLD : E_STOP;
            else ebi <= ebi + 4'd1;
          end else ecnt <= ecnt + 1'b1;
          E_HOLD: begin
            ecnt <= '0;
            if (!brk_hold) est <= E_STOP;
          end
          E_STOP: if (stop_done) est <= E_IDLE;
                  else ecnt <= ecnt + 1'b1;
          default: est <= E_IDLE;
        endcase
      end
    end
  end

  assign line_q    = (est == E_START || est == E_HOLD) ? 1'b0 :
                     (est == E_DATA) ? esh[0] : 1'b1;
  assign async_out = direct ? line_in : line_q;
endmodule

// File: rtl/rx_stop_restore_chk.sv
module rx_stop_restore_chk #(
  parameter int OVS         = 16,
  parameter int SHORT_BASIC = 2,
  parameter int SHORT_EXT   = 4,
  parameter int DEPTH       = 4,
  parameter int CW          = 4,
  parameter int AW          = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick16,
  input logic          bypass,
  input logic          hs_direct,
  input logic [2:0]    est,
  input logic [CW-1:0] ecnt,
  input logic          brk_hold,
  input logic          push,
  input logic [AW:0]   fcnt,
  input logic          line_q
);
  logic dir;
  assign dir = bypass | hs_direct;

  always @(posedge clk)
    if (!rst_n) AST_RESET_MARK: assert (line_q == 1'b1);   // R1

  AST_START_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (est == 3'd1 && tick16 && !dir && int'(ecnt) != OVS-1) |=> est == 3'd1);   // R2

  AST_STOP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (est == 3'd4 && tick16 && !dir && int'(ecnt) < OVS-SHORT_EXT-1) |=> est == 3'd4);   // R5

  AST_BRK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (est == 3'd3 && brk_hold && !dir) |=> est == 3'd3);   // R6

  AST_BYPASS_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> line_q);   // R7

  AST_HS_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    hs_direct |=> fcnt == '0);   // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> int'(fcnt) < DEPTH);   // R9
endmodule

bind rx_stop_restore rx_stop_restore_chk #(
  .OVS(OVS), .SHORT_BASIC(SHORT_BASIC), .SHORT_EXT(SHORT_EXT),
  .DEPTH(DEPTH), .CW(CW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .bypass(bypass),
  .hs_direct(hs_direct), .est(est), .ecnt(ecnt), .brk_hold(brk_hold),
  .push(push), .fcnt(fcnt), .line_q(line_q)
);

// File: tb/rx_stop_restore_bench.sv
module rx_stop_restore_bench;
  logic       clk = 1'b0, rst_n = 1'b0, rx_bit_stb = 1'b0, line_in = 1'b1, tick16 = 1'b0;
  logic [1:0] len_sel = 2'd0;
  logic       ext_range = 1'b0, bypass = 1'b0, hs_direct = 1'b0;
  logic       async_out;

  rx_stop_restore u_rx_stop_restore (
    .clk(clk), .rst_n(rst_n), .rx_bit_stb(rx_bit_stb), .line_in(line_in),
    .tick16(tick16), .len_sel(len_sel), .ext_range(ext_range),
    .bypass(bypass), .hs_direct(hs_direct), .async_out(async_out)
  );

  always #5 clk = ~clk;
  always @(negedge clk) tick16 <= ~tick16;

  int checks = 0, errors = 0, cyc = 0;
  bit mon_en = 1'b0, done = 1'b0;
  logic [9:0] exp_q[$];
  int falls[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic put_bit(bit b);
    line_in = b;
    repeat (15) @(negedge clk);
    rx_bit_stb = 1'b1;
    @(negedge clk);
    rx_bit_stb = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  task automatic send_char(logic [8:0] pay, bit keep_stop);
    int p = 6 + int'(len_sel);
    logic [8:0] m = (9'h1 << p) - 9'h1;
    exp_q.push_back({1'b0, pay & m});
    put_bit(1'b0);
    for (int i = 0; i < p; i++) put_bit(pay[i]);
    if (keep_stop) put_bit(1'b1);
  endtask

  task automatic drain();
    for (int i = 0; i < 6000 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (64) @(negedge clk);
  endtask

  // monitor: decodes async_out and pops the expected queue
  initial begin
    bit prev;
    logic [8:0] got;
    logic [9:0] e;
    logic stopv;
    int p;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (mon_en && prev && !async_out) begin
        falls.push_back(cyc);
        p = 6 + int'(len_sel);
        got = '0;
        repeat (16) @(negedge clk);
        chk(async_out == 1'b0, "R2 start element", async_out, 0);
        for (int i = 0; i < p; i++) begin
          repeat (32) @(negedge clk);
          got[i] = async_out;
        end
        repeat (32) @(negedge clk);
        stopv = async_out;
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected character", got, 0);
        else begin
          e = exp_q.pop_front();
          chk(got == e[8:0], "R2 R3 payload", got, e[8:0]);
          if (e[9]) begin
            chk(stopv == 1'b0, "R6 space at stop position", stopv, 0);
            while (!async_out) @(negedge clk);
          end else chk(stopv == 1'b1, "R4 stop element mark", stopv, 1);
        end
      end
      prev = async_out;
    end
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    chk(async_out == 1'b1, "R1 mark in reset", async_out, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(async_out == 1'b1, "R1 mark after reset", async_out, 1);
    mon_en = 1'b1;

    // R3: every length code
    for (int c = 0; c < 4; c++) begin
      len_sel = c[1:0];
      send_char(9'h0A5, 1'b1);
      send_char(9'h15A, 1'b1);
      send_char(9'h1FF, 1'b1);
      drain();
      chk(exp_q.size() == 0, "R3 all lengths delivered", exp_q.size(), 0);
    end
    chk(async_out == 1'b1, "R1 mark between characters", async_out, 1);

    // R4 R5: dropped stop, basic range
    len_sel = 2'd0; ext_range = 1'b0;
    falls.delete();
    send_char(9'h015, 1'b0);
    send_char(9'h02A, 1'b1);
    drain();
    chk(falls.size() == 2, "R4 two characters out", falls.size(), 2);
    d = (falls.size() == 2) ? falls[1] - falls[0] : -1;
    chk(d == 252, "R5 basic shortened stop", d, 252);

    // R5: extended range
    ext_range = 1'b1;
    falls.delete();
    send_char(9'h033, 1'b0);
    send_char(9'h00C, 1'b1);
    drain();
    d = (falls.size() == 2) ? falls[1] - falls[0] : -1;
    chk(d == 248, "R5 extended shortened stop", d, 248);

    // R9: stream with one dropped stop in four
    len_sel = 2'd2;
    for (int i = 0; i < 16; i++) send_char(9'((i * 37 + 5) & 9'h1FF), (i % 4) != 3);
    put_bit(1'b1);
    drain();
    chk(exp_q.size() == 0, "R9 stream fully delivered", exp_q.size(), 0);

    // R6: break
    len_sel = 2'd1; ext_range = 1'b0;
    exp_q.push_back(10'h200);
    for (int i = 0; i < 21; i++) put_bit(1'b0);
    chk(async_out == 1'b0, "R6 space held past character", async_out, 0);
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    drain();
    chk(async_out == 1'b1, "R6 mark after break", async_out, 1);
    send_char(9'h0C3, 1'b1);
    drain();
    chk(exp_q.size() == 0, "R6 recovery after break", exp_q.size(), 0);

    // R7: bypass
    mon_en = 1'b0;
    bypass = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); line_in = i[0]; #1;
      chk(async_out == line_in, "R7 bypass follows input", async_out, line_in);
    end
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
    line_in = 1'b1;
    @(negedge clk); bypass = 1'b0;
    repeat (200) @(negedge clk);
    chk(async_out == 1'b1, "R7 nothing emitted after bypass", async_out, 1);

    // R8: higher-speed direct path
    hs_direct = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); line_in = ~i[0]; #1;
      chk(async_out == line_in, "R8 direct follows input", async_out, line_in);
    end
    put_bit(1'b0); put_bit(1'b1);
    line_in = 1'b1;
    @(negedge clk); hs_direct = 1'b0;
    repeat (200) @(negedge clk);
    chk(async_out == 1'b1, "R8 buffer empty after direct mode", async_out, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule